// File: doc/BRIEF.md
# Copy Descriptor Validation Checker

This block sits between the descriptor fetch logic and the copy engine. Each fetched 32-byte copy descriptor is offered to it as eight 32-bit words with a valid strobe. Before any data moves, it checks the header control bits, the incoming status byte, the transfer length and both address ranges. It then returns a verdict: a status byte, a small error code, an abort flag for the copy engine, and a ready-made 32-bit word that the write-back path stores into the descriptor's status word.

The checker is a two-stage pipeline with no stall. It accepts a new descriptor on every clock and returns each verdict exactly two cycles later. When several faults are present at once, only the lowest-numbered fault is reported, so software sees one deterministic cause.

Top module: `dsc_validator`

## Requirements
- R1: A descriptor sampled with `desc_valid_i` high produces `res_valid_o` high for exactly one cycle, two clock edges later. While `res_valid_o` is low, status, error code and abort are all zero.
- R2: A descriptor with no fault yields status 0x03, error code 0 and abort low.
- R3: Error code 1 (header fault) is reported when header bit 0 (the go flag) is clear, or when header bits 15:8 are nonzero. Descriptor word k occupies `desc_i[32k+31:32k]`, and the word order is header, status word, length, reserved, source high, source low, destination high, destination low.
- R4: Error code 2 is reported when the incoming status byte (word 1, bits 7:0) is nonzero, meaning the descriptor was already processed.
- R5: Error code 3 is reported when the length is not a multiple of ALIGN_BYTES (default 4).
- R6: Error code 4 is reported when the source low word is not ALIGN_BYTES aligned. Error code 5 is reported when the destination low word is not ALIGN_BYTES aligned.
- R7: Error code 6 (range fault) is reported when a 64-bit address {high, low} has any bit set at or above ADDR_W (default 48), or when address plus length exceeds 2^ADDR_W. Ending exactly at 2^ADDR_W is legal.
- R8: Error code 7 (invalid descriptor) is reported when the length is zero or the reserved word is nonzero.
- R9: When several faults are present, the smallest applicable code is reported.
- R10: Any fault yields status 0x04 and abort high, with the error code in the range 1 to 7.
- R11: `res_word1_o` is {descriptor ID, error code, status}. The ID is word 1 bits 31:16, passed through unchanged, and the error code sits in bits 15:8.
- R12: Descriptors presented on consecutive cycles each get their own verdict, in order. Input words offered while `desc_valid_i` is low produce no verdict.
- R13: During reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_valid_i | input | 1 | Descriptor words are valid this cycle |
| desc_i | input | 256 | Eight descriptor words, word k at bits 32k+31:32k |
| res_valid_o | output | 1 | Verdict valid pulse |
| res_status_o | output | 8 | 0x03 on success, 0x04 on failure |
| res_err_o | output | 8 | Error code 0 to 7 |
| res_abort_o | output | 1 | Tells the copy engine to skip the descriptor |
| res_word1_o | output | 32 | Status word for write-back |

## Verification
Every verdict field is due at the same point: on the second rising edge after the descriptor was sampled. The bench's reference model stamps each expected verdict with that due cycle and pops it only when the cycle count reaches it. On every other cycle the bench expects an all-zero idle output. Inputs change and outputs are compared on the falling edge, so each comparison sees settled registers. Back-to-back and gapped streams both go through the same cycle-exact comparison.

// File: rtl/dsc_chk_pkg.sv
package dsc_chk_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 8;
  localparam int DESC_W    = WORD_W * NUM_WORDS;
  localparam int NUM_CODES = 7;
  localparam int CODE_W    = 8;

  // word positions are decoded by the fetch side; keep order
  localparam int W_HDR = 0;
  localparam int W_STS = 1;
  localparam int W_LEN = 2;
  localparam int W_RSV = 3;
  localparam int W_SHI = 4;
  localparam int W_SLO = 5;
  localparam int W_DHI = 6;
  localparam int W_DLO = 7;

  localparam logic [7:0] STAT_OK   = 8'h03;
  localparam logic [7:0] STAT_FAIL = 8'h04;

  // bit k set -> error code k+1
  typedef logic [NUM_CODES-1:0] fault_t;
endpackage

// File: rtl/dsc_range_chk.sv
module dsc_range_chk #(
  parameter int ADDR_W = 48
) (
  input  logic [31:0] hi_i,
  input  logic [31:0] lo_i,
  input  logic [31:0] len_i,
  output logic        bad_o
);
  localparam int HI_KEEP = ADDR_W - 32;

  logic [ADDR_W:0]   end_sum;
  logic              hi_over;
  logic [ADDR_W-1:0] base;

  assign base    = {hi_i[HI_KEEP-1:0], lo_i};
  assign hi_over = |hi_i[31:HI_KEEP];
  assign end_sum = {1'b0, base} + (ADDR_W+1)'(len_i);
  // ending exactly at 2^ADDR_W is legal
  assign bad_o   = hi_over | (end_sum[ADDR_W] & (|end_sum[ADDR_W-1:0]));
endmodule

// File: rtl/dsc_fault_scan.sv
module dsc_fault_scan
  import dsc_chk_pkg::*;
#(
  parameter int ALIGN_LSB = 2,
  parameter int ADDR_W    = 48
) (
  input  logic [DESC_W-1:0] desc_i,
  output fault_t            fault_o
);
  logic [WORD_W-1:0] w [NUM_WORDS];

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    assign w[k] = desc_i[k*WORD_W +: WORD_W];
  end

  logic [1:0] range_bad;
  localparam int SIDES = 2;
  localparam int HI_IDX [SIDES] = '{W_SHI, W_DHI};
  localparam int LO_IDX [SIDES] = '{W_SLO, W_DLO};

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    dsc_range_chk #(.ADDR_W(ADDR_W)) u_rng (
      .hi_i  (w[HI_IDX[s]]),
      .lo_i  (w[LO_IDX[s]]),
      .len_i (w[W_LEN]),
      .bad_o (range_bad[s])
    );
  end

  // timestamp, free control bits and old error byte are not inspected
  logic unused_bits;
  assign unused_bits = ^{w[W_HDR][31:16], w[W_HDR][7:1], w[W_STS][31:8]};

  always_comb begin
    fault_o    = '0;
    fault_o[0] = ~w[W_HDR][0] | (|w[W_HDR][15:8]);
    fault_o[1] = |w[W_STS][7:0];
    fault_o[2] = |w[W_LEN][ALIGN_LSB-1:0];
    fault_o[3] = |w[W_SLO][ALIGN_LSB-1:0];
    fault_o[4] = |w[W_DLO][ALIGN_LSB-1:0];
    fault_o[5] = |range_bad;
    fault_o[6] = (w[W_LEN] == '0) | (|w[W_RSV]);
  end
endmodule

// File: rtl/dsc_prio_enc.sv
module dsc_prio_enc
  import dsc_chk_pkg::*;
(
  input  fault_t            fault_i,
  output logic [CODE_W-1:0] code_o,
  output logic              any_o
);
  always_comb begin
    code_o = '0;
    for (int k = NUM_CODES - 1; k >= 0; k--) begin
      if (fault_i[k]) code_o = CODE_W'(k + 1);
    end
  end
  assign any_o = |fault_i;
endmodule

// File: rtl/dsc_result_reg.sv
module dsc_result_reg
  import dsc_chk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              any_i,
  input  logic [15:0]       id_i,
  output logic              vld_o,
  output logic [7:0]        status_o,
  output logic [CODE_W-1:0] err_o,
  output logic              abort_o,
  output logic [15:0]       id_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o    <= 1'b0;
      status_o <= '0;
      err_o    <= '0;
      abort_o  <= 1'b0;
      id_o     <= '0;
    end else if (vld_i) begin
      vld_o    <= 1'b1;
      status_o <= any_i ? STAT_FAIL : STAT_OK;
      err_o    <= code_i;
      abort_o  <= any_i;
      id_o     <= id_i;
    end else begin
      vld_o    <= 1'b0;
      status_o <= '0;
      err_o    <= '0;
      abort_o  <= 1'b0;
      id_o     <= '0;
    end
  end
endmodule

// File: rtl/dsc_validator.sv
module dsc_validator
  import dsc_chk_pkg::*;
#(
  parameter int ALIGN_BYTES = 4,
  parameter int ADDR_W      = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              desc_valid_i,
  input  logic [DESC_W-1:0] desc_i,
  output logic              res_valid_o,
  output logic [7:0]        res_status_o,
  output logic [7:0]        res_err_o,
  output logic              res_abort_o,
  output logic [31:0]       res_word1_o
);
  localparam int ALIGN_LSB = $clog2(ALIGN_BYTES);
  localparam int ID_LSB    = W_STS * WORD_W + 16;

  fault_t fault_d, s1_fault;
  logic   s1_vld;
  logic [15:0] s1_id, s2_id;
  logic [CODE_W-1:0] code;
  logic   any_fault;

  dsc_fault_scan #(.ALIGN_LSB(ALIGN_LSB), .ADDR_W(ADDR_W)) u_scan (
    .desc_i  (desc_i),
    .fault_o (fault_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld   <= 1'b0;
      s1_fault <= '0;
      s1_id    <= '0;
    end else begin
      s1_vld <= desc_valid_i;
      if (desc_valid_i) begin
        s1_fault <= fault_d;
        s1_id    <= desc_i[ID_LSB +: 16];
      end
    end
  end

  dsc_prio_enc u_prio (
    .fault_i (s1_fault),
    .code_o  (code),
    .any_o   (any_fault)
  );

  dsc_result_reg u_res (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (s1_vld),
    .code_i   (code),
    .any_i    (any_fault),
    .id_i     (s1_id),
    .vld_o    (res_valid_o),
    .status_o (res_status_o),
    .err_o    (res_err_o),
    .abort_o  (res_abort_o),
    .id_o     (s2_id)
  );

  assign res_word1_o = {s2_id, res_err_o, res_status_o};
endmodule

// File: rtl/dsc_chk_sva.sv
module dsc_chk_sva (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         desc_valid_i,
  input logic [255:0] desc_i,
  input logic         res_valid_o,
  input logic [7:0]   res_status_o,
  input logic [7:0]   res_err_o,
  input logic         res_abort_o,
  input logic [31:0]  res_word1_o
);
  p_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_i |=> ##1 res_valid_o);

  p_idle_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> (res_status_o == 8'h00 && res_err_o == 8'h00 && !res_abort_o));

  p_ok_fields_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_abort_o) |-> (res_status_o == 8'h03 && res_err_o == 8'h00));

  p_fail_fields_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_abort_o) |->
      (res_status_o == 8'h04 && res_err_o >= 8'd1 && res_err_o <= 8'd7));

  p_id_pass_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_i |=> ##1 (res_word1_o[31:16] == $past(desc_i[63:48], 2)));

  p_pack_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (res_word1_o[15:0] == {res_err_o, res_status_o}));
endmodule

bind dsc_validator dsc_chk_sva u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .desc_valid_i (desc_valid_i),
  .desc_i       (desc_i),
  .res_valid_o  (res_valid_o),
  .res_status_o (res_status_o),
  .res_err_o    (res_err_o),
  .res_abort_o  (res_abort_o),
  .res_word1_o  (res_word1_o)
);

// File: tb/tb_dsc_validator.sv
module tb_dsc_validator;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         desc_valid_i = 1'b0;
  logic [255:0] desc_i = '0;
  logic         res_valid_o;
  logic [7:0]   res_status_o;
  logic [7:0]   res_err_o;
  logic         res_abort_o;
  logic [31:0]  res_word1_o;

  dsc_validator dut (
    .clk_i, .rst_ni, .desc_valid_i, .desc_i,
    .res_valid_o, .res_status_o, .res_err_o, .res_abort_o, .res_word1_o
  );

  always #5 clk_i = ~clk_i;

  typedef struct {
    int          due;
    logic [7:0]  st;
    logic [7:0]  err;
    logic        ab;
    logic [15:0] id;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [255:0] mk(input logic [31:0] hdr, st, len, rsv, shi, slo, dhi, dlo);
    return {dlo, dhi, slo, shi, rsv, len, st, hdr};
  endfunction

  function automatic int range_bad(input logic [31:0] hi, lo, len);
    longint unsigned a, lim;
    a   = {hi, lo};
    lim = 64'h1 << 48;
    if (a >= lim) return 1;
    if (a + len > lim) return 1;
    return 0;
  endfunction

  function automatic int ref_code(input logic [255:0] d);
    logic [31:0] h, s, l, r, shi, slo, dhi, dlo;
    h = d[31:0]; s = d[63:32]; l = d[95:64]; r = d[127:96];
    shi = d[159:128]; slo = d[191:160]; dhi = d[223:192]; dlo = d[255:224];
    if (h[0] == 1'b0 || h[15:8] != 0) return 1;
    if (s[7:0] != 0) return 2;
    if (l % 4 != 0) return 3;
    if (slo % 4 != 0) return 4;
    if (dlo % 4 != 0) return 5;
    if (range_bad(shi, slo, l) != 0 || range_bad(dhi, dlo, l) != 0) return 6;
    if (l == 0 || r != 0) return 7;
    return 0;
  endfunction

  task automatic compare();
    exp_t e;
    total++;
    if (!rst_ni) begin
      if (res_valid_o !== 1'b0 || res_status_o !== 8'h00 || res_err_o !== 8'h00 ||
          res_abort_o !== 1'b0 || res_word1_o !== 32'h0) begin
        bad++;
        $display("FAIL R13 reset: got v=%0b st=%h err=%h ab=%0b w=%h exp all zero",
                 res_valid_o, res_status_o, res_err_o, res_abort_o, res_word1_o);
      end
    end else if (exp_q.size() != 0 && exp_q[0].due == cyc) begin
      e = exp_q.pop_front();
      if (res_valid_o !== 1'b1 || res_status_o !== e.st || res_err_o !== e.err ||
          res_abort_o !== e.ab || res_word1_o !== {e.id, e.err, e.st}) begin
        bad++;
        $display("FAIL %s: got v=%0b st=%h err=%h ab=%0b w=%h exp v=1 st=%h err=%h ab=%0b w=%h",
                 e.tag, res_valid_o, res_status_o, res_err_o, res_abort_o, res_word1_o,
                 e.st, e.err, e.ab, {e.id, e.err, e.st});
      end
    end else begin
      if (res_valid_o !== 1'b0 || res_status_o !== 8'h00 || res_err_o !== 8'h00 ||
          res_abort_o !== 1'b0) begin
        bad++;
        $display("FAIL R1/R12 idle: got v=%0b st=%h err=%h ab=%0b exp v=0 st=00 err=00 ab=0",
                 res_valid_o, res_status_o, res_err_o, res_abort_o);
      end
    end
  endtask

  // one cycle: compare at falling edge, then drive the next input
  task automatic step(input logic v, input logic [255:0] d, input string tag);
    exp_t e;
    int c;
    @(negedge clk_i);
    compare();
    desc_valid_i = v;
    desc_i = d;
    if (v) begin
      c     = ref_code(d);
      e.due = cyc + 2;
      e.err = 8'(c);
      e.ab  = (c != 0);
      e.st  = (c != 0) ? 8'h04 : 8'h03;
      e.id  = d[63:48];
      e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  localparam logic [31:0] HOK = 32'h1234_0001;

  initial begin
    logic [255:0] g;
    repeat (3) begin
      @(negedge clk_i);
      compare();
    end
    rst_ni = 1'b1;
    step(0, '0, "R1");
    // R2 clean descriptor, ID passthrough R11
    step(1, mk(HOK, 32'hBEEF_0000, 32'd64, 0, 0, 32'h1000, 0, 32'h2000), "R2/R11");
    step(0, '0, "R1");
    step(0, '0, "R1");
    // R3 go flag clear, control byte nonzero
    step(1, mk(32'h0000_0000, 32'hA001_0000, 32'd8, 0, 0, 32'h100, 0, 32'h200), "R3");
    step(1, mk(32'h0000_0101, 32'hA002_0000, 32'd8, 0, 0, 32'h100, 0, 32'h200), "R3");
    // R4 already-processed status
    step(1, mk(HOK, 32'hA003_0003, 32'd8, 0, 0, 32'h100, 0, 32'h200), "R4");
    // R5 length alignment
    step(1, mk(HOK, 32'hA004_0000, 32'd10, 0, 0, 32'h100, 0, 32'h200), "R5");
    // R6 source / destination alignment
    step(1, mk(HOK, 32'hA005_0000, 32'd8, 0, 0, 32'h101, 0, 32'h200), "R6");
    step(1, mk(HOK, 32'hA006_0000, 32'd8, 0, 0, 32'h100, 0, 32'h202), "R6");
    // R7 range: exact end legal, one word past illegal, high bits set
    step(1, mk(HOK, 32'hA007_0000, 32'd16, 0, 32'h0000_FFFF, 32'hFFFF_FFF0, 0, 32'h200), "R7");
    step(1, mk(HOK, 32'hA008_0000, 32'd20, 0, 32'h0000_FFFF, 32'hFFFF_FFF0, 0, 32'h200), "R7");
    step(1, mk(HOK, 32'hA009_0000, 32'd8, 0, 0, 32'h100, 32'h0001_0000, 32'h200), "R7");
    // R8 zero length, reserved nonzero
    step(1, mk(HOK, 32'hA00A_0000, 32'd0, 0, 0, 32'h100, 0, 32'h200), "R8");
    step(1, mk(HOK, 32'hA00B_0000, 32'd8, 32'h1, 0, 32'h100, 0, 32'h200), "R8");
    // R9 several faults: lowest code wins
    step(1, mk(HOK, 32'hA00C_0000, 32'd6, 32'h5, 0, 32'h101, 0, 32'h203), "R9");
    step(1, mk(32'h0, 32'hA00D_0007, 32'd0, 0, 0, 32'h101, 0, 32'h200), "R9");
    step(1, mk(HOK, 32'hA00E_0000, 32'd0, 0, 0, 32'h100, 32'hFFFF_0000, 32'h200), "R9/R10");
    // R12 garbage without valid is ignored
    step(0, '1, "R12");
    step(0, {8{32'hDEAD_BEE1}}, "R12");
    step(0, '0, "R12");
    // R12 random mixed stream
    for (int i = 0; i < 2000; i++) begin
      g = mk({$urandom} & (($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : 32'hFFFF_00FF) | 32'h1,
             {$urandom} & (($urandom_range(0, 4) == 0) ? 32'hFFFF_FFFF : 32'hFFFF_0000),
             ($urandom_range(0, 9) == 0) ? 32'd0 : ({$urandom} & (($urandom_range(0, 3) == 0) ? 32'hFFF : 32'hFFC)),
             ($urandom_range(0, 9) == 0) ? 32'd1 : 32'd0,
             ($urandom_range(0, 5) == 0) ? {$urandom} : 32'h0000_FFFF * $urandom_range(0, 1),
             {$urandom} & (($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : 32'hFFFF_FFFC),
             ($urandom_range(0, 5) == 0) ? {$urandom} : 32'h0000_FFFF * $urandom_range(0, 1),
             {$urandom} & (($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : 32'hFFFF_FFFC));
      step($urandom_range(0, 3) != 0, g, "R9/R12");
    end
    repeat (4) step(0, '0, "R1");
    if (exp_q.size() != 0) begin
      total++;
      bad++;
      $display("FAIL R12: %0d verdicts never checked, exp 0", exp_q.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog: got hang exp finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule